// File: doc/BRIEF.md
# Three-Wire Serial Byte Engine

This block runs a synchronous three-wire link to an external timekeeping memory. The three lines are an active-low device reset, a serial clock, and a bidirectional data line. The data line leaves the block as a separate output value and output-enable pair, and comes back as a separate input. A parent controller chooses an operation with `op`, pulses `start`, and waits for the one-cycle `done`. There are three operations: a bus reset pulse, a one-byte write, or a one-byte read. The parent builds whole commands, addresses and data buffers from these byte operations.

Every step on the wire lasts one phase, which is `PHASE_CLKS` system clocks long. The reset pulse holds the device reset low for `RST_HOLD_PHASES` phases. It then allows one phase of settle time. Bytes travel least-significant bit first. The block never drives the data line while it reads it. The data input passes through a two-flop synchroniser before it is sampled, so `PHASE_CLKS` must be at least 4.

Top module: `tw_byte_engine`

## Requirements
- R1: While `rst` is high and after it falls, the lines rest with `line_rst_n`=1, `line_clk`=1 and `line_dq_oe`=0. `busy`, `done` and `rdata` are all 0.
- R2: The operation with `op`=0 drives `line_rst_n` low, with the data line released, for exactly RST_HOLD_PHASES×PHASE_CLKS cycles. `done` follows (RST_HOLD_PHASES+1)×PHASE_CLKS cycles after the start edge.
- R3: After the reset operation finishes, the lines stay at `line_rst_n`=1, `line_clk`=0, `line_dq_oe`=1 and `line_dq_o`=0.
- R4: The operation with `op`=1 sends `wdata` as 8 bits, bit 0 first. For each bit, the data line is driven with the bit while the clock is low for one phase. The clock is then high for one phase and low for one phase. A device that captures the data on each rising clock edge receives `wdata`.
- R5: During a write, `line_dq_o` does not change while `line_clk` is high.
- R6: A write raises `done` 24×PHASE_CLKS cycles after the start edge. At that point `line_clk`=0, `line_dq_oe`=1 and `line_dq_o` holds bit 7 of the byte.
- R7: The operation with `op`=2 keeps `line_dq_oe` at 0 for its whole length. For each bit, it holds the clock low for one phase and samples the synchronised data at the end of that phase. It then holds the clock high for one phase. The first bit sampled becomes `rdata` bit 0.
- R8: A read raises `done` 16×PHASE_CLKS cycles after the start edge, and leaves `line_clk`=1 and `line_dq_oe`=0. `rdata` changes only in the `done` cycle of a read, and it holds through later operations.
- R9: `done` lasts exactly one cycle, and `busy` is 0 in that cycle. `busy` is 1 from the cycle after the start edge until `done`.
- R10: A `start` that arrives while `busy` is 1 is ignored. The running operation finishes with its own timing and data, and no operation follows it.
- R11: `start` with `op`=3 is ignored: `busy` and `done` stay 0 and the lines do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin the operation chosen by `op` when not busy |
| op | input | 2 | 0 bus reset, 1 write byte, 2 read byte, 3 none |
| wdata | input | 8 | Byte to send on a write |
| rdata | output | 8 | Last byte received |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | An operation is in progress |
| line_rst_n | output | 1 | Active-low device reset line |
| line_clk | output | 1 | Serial clock line |
| line_dq_o | output | 1 | Data line output value |
| line_dq_oe | output | 1 | Data line output enable (0 = released) |
| line_dq_i | input | 1 | Data line input value (asynchronous) |

## Verification
The result of each operation is due a fixed number of cycles after the start edge. A write completes after 24 phases, a read after 16 phases, and a reset after RST_HOLD_PHASES+1 phases. The bench samples on the falling system clock. It counts those falls from the first one after the start edge, and it requires `done` at exactly that count, not merely before a deadline. Line activity is tracked by comparing the serial clock with its value at the previous sample. Written bits are captured at each rise, and `rdata` is compared in the `done` cycle itself.

// File: rtl/tw_pkg.sv
package tw_pkg;

    localparam int TW_BYTE_W = 8;
    localparam int TW_IDX_W  = $clog2(TW_BYTE_W);

    typedef enum logic [1:0] {
        TW_OP_RESET = 2'd0,
        TW_OP_WRITE = 2'd1,
        TW_OP_READ  = 2'd2,
        TW_OP_NONE  = 2'd3
    } tw_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RST_HOLD,
        ST_RST_SETTLE,
        ST_WR_SETUP,
        ST_WR_HIGH,
        ST_WR_LOW,
        ST_RD_LOW,
        ST_RD_HIGH
    } tw_state_e;

    typedef struct packed {
        logic rst_n;
        logic sclk;
        logic dq_oe;
        logic dq_o;
    } tw_lines_t;

    localparam tw_lines_t TW_LINES_REST = '{rst_n: 1'b1, sclk: 1'b1, dq_oe: 1'b0, dq_o: 1'b0};

    // Line levels applied on entry to a state; levels a state does not own are kept.
    function automatic tw_lines_t tw_lines_on_entry(tw_state_e st, tw_lines_t cur, logic bit_val);
        tw_lines_t n;
        n = cur;
        case (st)
            ST_RST_HOLD: begin
                n.rst_n = 1'b0;
                n.dq_oe = 1'b0;
                n.dq_o  = 1'b0;
            end
            ST_RST_SETTLE: begin
                n.rst_n = 1'b1;
                n.sclk  = 1'b0;
                n.dq_oe = 1'b1;
                n.dq_o  = 1'b0;
            end
            ST_WR_SETUP: begin
                n.rst_n = 1'b1;
                n.sclk  = 1'b0;
                n.dq_oe = 1'b1;
                n.dq_o  = bit_val;
            end
            ST_WR_HIGH: n.sclk = 1'b1;
            ST_WR_LOW:  n.sclk = 1'b0;
            ST_RD_LOW: begin
                n.rst_n = 1'b1;
                n.sclk  = 1'b0;
                n.dq_oe = 1'b0;
                n.dq_o  = 1'b0;
            end
            ST_RD_HIGH: n.sclk = 1'b1;
            default: ;
        endcase
        return n;
    endfunction

    function automatic tw_state_e tw_first_state(tw_op_e op);
        case (op)
            TW_OP_RESET: return ST_RST_HOLD;
            TW_OP_WRITE: return ST_WR_SETUP;
            TW_OP_READ:  return ST_RD_LOW;
            default:     return ST_IDLE;
        endcase
    endfunction

    function automatic logic tw_is_read(tw_state_e st);
        return (st == ST_RD_LOW) || (st == ST_RD_HIGH);
    endfunction

endpackage

// File: rtl/tw_phase_timer.sv
module tw_phase_timer #(
    parameter int PHASE_CLKS  = 4,
    parameter int HOLD_PHASES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic long_mode,
    output logic phase_end
);
    localparam int CYC_W = (PHASE_CLKS > 1) ? $clog2(PHASE_CLKS) : 1;
    localparam int PH_W  = (HOLD_PHASES > 1) ? $clog2(HOLD_PHASES) : 1;
    localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(PHASE_CLKS - 1);
    localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(HOLD_PHASES - 1);

    logic [CYC_W-1:0] cyc;
    logic [PH_W-1:0]  ph;
    logic             cyc_wrap;

    assign cyc_wrap  = (cyc == CYC_LAST);
    assign phase_end = cyc_wrap && (!long_mode || (ph == PH_LAST));

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cyc <= '0;
            ph  <= '0;
        end else if (cyc_wrap) begin
            cyc <= '0;
            ph  <= ph + PH_W'(1);
        end else begin
            cyc <= cyc + CYC_W'(1);
        end
    end

endmodule

// File: rtl/tw_sync.sv
module tw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/tw_seq.sv
module tw_seq
    import tw_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  tw_op_e               op,
    input  logic [TW_BYTE_W-1:0] wdata,
    input  logic                 phase_end,
    input  logic                 din_s,
    output tw_lines_t            lines,
    output logic                 busy,
    output logic                 done,
    output logic [TW_BYTE_W-1:0] rdata,
    output logic                 restart,
    output logic                 long_mode
);
    tw_state_e            state, nxt;
    logic                 enter;
    logic                 bit_val;
    logic                 last_bit;
    logic                 accept;
    logic [TW_IDX_W-1:0]  bit_idx;
    logic [TW_BYTE_W-1:0] wsh;
    logic [TW_BYTE_W-1:0] rsh;

    assign accept    = start && (state == ST_IDLE) && (op != TW_OP_NONE);
    assign last_bit  = (bit_idx == TW_IDX_W'(TW_BYTE_W - 1));
    assign busy      = (state != ST_IDLE);
    assign restart   = enter;
    assign long_mode = (state == ST_RST_HOLD);

    always_comb begin
        nxt     = state;
        enter   = 1'b0;
        bit_val = wsh[0];
        case (state)
            ST_IDLE: begin
                bit_val = wdata[0];
                if (accept) begin
                    enter = 1'b1;
                    nxt   = tw_first_state(op);
                end
            end
            ST_RST_HOLD:   if (phase_end) begin enter = 1'b1; nxt = ST_RST_SETTLE; end
            ST_RST_SETTLE: if (phase_end) begin enter = 1'b1; nxt = ST_IDLE; end
            ST_WR_SETUP:   if (phase_end) begin enter = 1'b1; nxt = ST_WR_HIGH; end
            ST_WR_HIGH:    if (phase_end) begin enter = 1'b1; nxt = ST_WR_LOW; end
            ST_WR_LOW: begin
                bit_val = wsh[1];
                if (phase_end) begin
                    enter = 1'b1;
                    nxt   = last_bit ? ST_IDLE : ST_WR_SETUP;
                end
            end
            ST_RD_LOW:     if (phase_end) begin enter = 1'b1; nxt = ST_RD_HIGH; end
            ST_RD_HIGH: begin
                if (phase_end) begin
                    enter = 1'b1;
                    nxt   = last_bit ? ST_IDLE : ST_RD_LOW;
                end
            end
            default: begin
                enter = 1'b1;
                nxt   = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            lines   <= TW_LINES_REST;
            bit_idx <= '0;
            wsh     <= '0;
            rsh     <= '0;
            rdata   <= '0;
            done    <= 1'b0;
        end else begin
            done <= enter && (nxt == ST_IDLE);
            if (enter) begin
                state <= nxt;
                lines <= tw_lines_on_entry(nxt, lines, bit_val);
            end
            if (accept) begin
                wsh     <= wdata;
                bit_idx <= '0;
            end
            if (phase_end && (state == ST_WR_LOW)) begin
                wsh     <= wsh >> 1;
                bit_idx <= bit_idx + TW_IDX_W'(1);
            end
            if (phase_end && (state == ST_RD_LOW)) begin
                rsh <= {din_s, rsh[TW_BYTE_W-1:1]};
            end
            if (phase_end && (state == ST_RD_HIGH)) begin
                bit_idx <= bit_idx + TW_IDX_W'(1);
                if (last_bit) rdata <= rsh;
            end
        end
    end

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (rst) done |-> !busy);

    // R7
    read_release_chk: assert property (@(posedge clk) disable iff (rst)
        tw_is_read(state) |-> !lines.dq_oe);

endmodule

// File: rtl/tw_byte_engine.sv
module tw_byte_engine
    import tw_pkg::*;
#(
    parameter int PHASE_CLKS      = 4,
    parameter int RST_HOLD_PHASES = 8,
    parameter int SYNC_STAGES     = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [1:0] op,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       done,
    output logic       busy,
    output logic       line_rst_n,
    output logic       line_clk,
    output logic       line_dq_o,
    output logic       line_dq_oe,
    input  logic       line_dq_i
);
    tw_lines_t lines;
    logic      phase_end;
    logic      restart;
    logic      long_mode;
    logic      din_s;

    tw_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (line_dq_i),
        .q   (din_s)
    );

    tw_phase_timer #(.PHASE_CLKS(PHASE_CLKS), .HOLD_PHASES(RST_HOLD_PHASES)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .restart   (restart),
        .long_mode (long_mode),
        .phase_end (phase_end)
    );

    tw_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .op        (tw_op_e'(op)),
        .wdata     (wdata),
        .phase_end (phase_end),
        .din_s     (din_s),
        .lines     (lines),
        .busy      (busy),
        .done      (done),
        .rdata     (rdata),
        .restart   (restart),
        .long_mode (long_mode)
    );

    assign line_rst_n = lines.rst_n;
    assign line_clk   = lines.sclk;
    assign line_dq_o  = lines.dq_o;
    assign line_dq_oe = lines.dq_oe;

    // R2
    rst_line_busy_chk: assert property (@(posedge clk) disable iff (rst) !line_rst_n |-> busy);

    // R5
    dq_steady_chk: assert property (@(posedge clk) disable iff (rst)
        (line_clk && $past(line_clk) && line_dq_oe && $past(line_dq_oe))
        |-> (line_dq_o == $past(line_dq_o)));

    // R8
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rdata != $past(rdata)) |-> done);

endmodule

// File: tb/test_tw_byte_engine.sv
module test_tw_byte_engine;
    localparam int P = 4;
    localparam int H = 8;

    logic       clk;
    logic       rst;
    logic       start;
    logic [1:0] op;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic       done;
    logic       busy;
    logic       line_rst_n;
    logic       line_clk;
    logic       line_dq_o;
    logic       line_dq_oe;
    logic       line_dq_i;

    int checks = 0;
    int errors = 0;

    tw_byte_engine #(.PHASE_CLKS(P), .RST_HOLD_PHASES(H)) i_tw_byte_engine (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .op         (op),
        .wdata      (wdata),
        .rdata      (rdata),
        .done       (done),
        .busy       (busy),
        .line_rst_n (line_rst_n),
        .line_clk   (line_clk),
        .line_dq_o  (line_dq_o),
        .line_dq_oe (line_dq_oe),
        .line_dq_i  (line_dq_i)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    // Device model and line monitor, sampled on the falling system clock
    logic       prev_sclk = 1'b1;
    logic       wr_active = 1'b0;
    logic       rd_active = 1'b0;
    logic [7:0] wr_cap = 8'h00;
    int         wr_bits = 0;
    logic       wr_last = 1'b0;
    int         dq_glitch = 0;
    logic [3:0] rd_rises = 4'd0;
    logic [7:0] dev_byte = 8'h00;

    assign line_dq_i = dev_byte[rd_rises[2:0]];

    always @(negedge clk) begin
        if (wr_active && line_dq_oe && line_clk && !prev_sclk) begin
            wr_cap  = {line_dq_o, wr_cap[7:1]};
            wr_bits = wr_bits + 1;
            wr_last = line_dq_o;
        end else if (wr_active && line_clk && prev_sclk && (line_dq_o != wr_last)) begin
            dq_glitch = dq_glitch + 1;
        end
        if (rd_active && !line_dq_oe && line_clk && !prev_sclk)
            rd_rises = rd_rises + 4'd1;
        prev_sclk = line_clk;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    int rst_low;
    int rd_oe_seen;
    int busy_gap;

    task automatic run_op(input logic [1:0] o, input logic [7:0] wd, input int inject, output int cycles);
        @(negedge clk);
        wr_active  = (o == 2'd1);
        rd_active  = (o == 2'd2);
        wr_cap     = 8'h00;
        wr_bits    = 0;
        dq_glitch  = 0;
        rd_rises   = 4'd0;
        rst_low    = 0;
        rd_oe_seen = 0;
        busy_gap   = 0;
        start      = 1'b1;
        op         = o;
        wdata      = wd;
        @(negedge clk);
        start  = 1'b0;
        cycles = 0;
        chk("R9 busy after start", int'(busy), 1);
        while (!done && cycles < 100000) begin
            if (!line_rst_n) rst_low++;
            if (rd_active && line_dq_oe) rd_oe_seen++;
            if (inject > 0 && cycles == inject) begin
                start = 1'b1;
                op    = 2'd2;
                wdata = ~wd;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cycles++;
            if (!done && !busy) busy_gap++;
        end
        start = 1'b0;
        if (cycles >= 100000) chk("R9 done never seen", cycles, 0);
        chk("R9 busy low in done cycle", int'(busy), 0);
        chk("R9 busy without gap", busy_gap, 0);
        wr_active = 1'b0;
        rd_active = 1'b0;
    endtask

    initial begin
        #(4 * 190000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int cyc;
        logic [7:0] held;
        rst   = 1'b1;
        start = 1'b0;
        op    = 2'd0;
        wdata = 8'h00;
        repeat (5) @(negedge clk);
        // R1 during reset
        chk("R1 rst_n in reset", int'(line_rst_n), 1);
        chk("R1 clk in reset", int'(line_clk), 1);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 rst_n", int'(line_rst_n), 1);
        chk("R1 clk", int'(line_clk), 1);
        chk("R1 dq_oe", int'(line_dq_oe), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 rdata", int'(rdata), 0);

        // R11: op code 3 does nothing
        start = 1'b1;
        op    = 2'd3;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chk("R11 busy", int'(busy), 0);
            chk("R11 done", int'(done), 0);
            chk("R11 lines", int'({line_rst_n, line_clk, line_dq_oe}), 3'b110);
            @(negedge clk);
        end

        // R2 / R3: bus reset from resting lines
        run_op(2'd0, 8'h00, 0, cyc);
        chk("R2 reset duration", cyc, (H + 1) * P);
        chk("R2 rst_n low cycles", rst_low, H * P);
        chk("R3 rst_n after", int'(line_rst_n), 1);
        chk("R3 clk after", int'(line_clk), 0);
        chk("R3 dq_oe after", int'(line_dq_oe), 1);
        chk("R3 dq_o after", int'(line_dq_o), 0);
        @(negedge clk);
        chk("R9 done one cycle", int'(done), 0);

        // R4 / R5 / R6: every byte value
        for (int b = 0; b < 256; b++) begin
            run_op(2'd1, 8'(b), 0, cyc);
            chk("R4 byte captured", int'(wr_cap), b);
            chk("R4 bit count", wr_bits, 8);
            chk("R5 data moved while clk high", dq_glitch, 0);
            chk("R6 write duration", cyc, 24 * P);
            chk("R6 end lines", int'({line_clk, line_dq_oe, line_dq_o}), {2'b01, b[7]});
            chk("R8 rdata untouched by write", int'(rdata), 0);
        end

        // R7 / R8: every byte value
        for (int b = 0; b < 256; b++) begin
            dev_byte = 8'(b);
            run_op(2'd2, 8'h00, 0, cyc);
            chk("R7 rdata", int'(rdata), b);
            chk("R7 dq driven during read", rd_oe_seen, 0);
            chk("R8 read duration", cyc, 16 * P);
            chk("R8 end lines", int'({line_clk, line_dq_oe}), 2'b10);
            @(negedge clk);
            chk("R9 done one cycle after read", int'(done), 0);
        end

        // R8: rdata holds through a write and a reset
        held = rdata;
        run_op(2'd1, 8'h3C, 0, cyc);
        chk("R8 rdata held after write", int'(rdata), int'(held));
        run_op(2'd0, 8'h00, 0, cyc);
        chk("R8 rdata held after reset", int'(rdata), int'(held));
        chk("R2 reset after read duration", cyc, (H + 1) * P);
        chk("R2 rst_n low cycles again", rst_low, H * P);

        // R10: start while busy is ignored
        dev_byte = 8'h00;
        run_op(2'd1, 8'hA5, 10, cyc);
        chk("R10 write byte kept", int'(wr_cap), 8'hA5);
        chk("R10 write duration kept", cyc, 24 * P);
        chk("R10 rdata unchanged", int'(rdata), int'(held));
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R10 no queued op", int'(busy), 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule